// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from six sources: two comparator outputs, one external pin, two timer overflow strobes and an analog-to-digital completion strobe. The comparator and external inputs are levels, and a falling edge on one of them latches that source's request flag. The timer and converter inputs are one-cycle pulses that latch their flags directly. Software sees the controller as two 8-bit registers. Each register holds per-source enable bits and request flags, and register 0 also holds the master enable.

When the master enable is set, at least one source has both its enable and its flag set, and the call stack is not full, the controller raises a call request. The request carries the vector address of the eligible source with the lowest address. When the core acknowledges, the controller clears that source's flag and the master enable in the same edge. Flags keep latching while masked. Software can set the master enable again inside a handler to allow nesting.

The controller also drives a wake-up output for a sleeping core. This output does not depend on the master enable or the stack state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `call_req` is 0 and `wake` is 0.
- R2: Register 0 (`reg_addr`=0) holds the master enable in bit 0. Bits 1, 2 and 3 are the enables for comparator 0, comparator 1 and external. Bits 4, 5 and 6 are the flags for comparator 0, comparator 1 and external. Bit 7 always reads 0. All seven stored bits are writable.
- R3: Register 1 (`reg_addr`=1) holds the enables for timer 0, timer 1 and the converter in bits 0, 1 and 2. Their flags are in bits 4, 5 and 6. Bits 3 and 7 always read 0.
- R4: A 1-to-0 change on `cmp0_in`, `cmp1_in` or `ext_in` sets that source's flag. Both the old and the new level must each be seen at a rising clock edge. The flag reads 1 after the second rising edge that follows the fall. A rising change or a steady level sets nothing.
- R5: A 1 on `tmr0_ovf`, `tmr1_ovf` or `adc_done` at a rising edge sets that source's flag at that edge.
- R6: `call_req` is 1 exactly when the master enable is 1, `stack_full` is 0, and some source has both its enable and its flag at 1. It follows its inputs within the same cycle.
- R7: `call_vec` is 0x04 for comparator 0, 0x08 for comparator 1, 0x0C for external, 0x10 for timer 0, 0x14 for timer 1 and 0x18 for the converter. It reads 0x00 when no source is eligible.
- R8: When several sources are eligible, `call_vec` selects the one with the lowest vector address.
- R9: `call_ack`=1 at a rising edge while `call_req`=1 clears the selected source's flag and the master enable at that edge. Other bits are unchanged. `call_ack` has no effect while `call_req`=0.
- R10: Flags stay latched while masked. After an acknowledge, setting the master enable again lets the next pending source be taken.
- R11: `wake` is 1 whenever some source has both its enable and its flag at 1. This holds regardless of the master enable and `stack_full`.
- R12: When a hardware set and a software write clearing the same flag land at the same edge, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select, 0 or 1 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| cmp0_in | input | 1 | Comparator 0 output level |
| cmp1_in | input | 1 | Comparator 1 output level |
| ext_in | input | 1 | External interrupt pin level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | Converter completion pulse |
| stack_full | input | 1 | Call stack is full |
| call_req | output | 1 | Interrupt call request |
| call_vec | output | VEC_W | Vector address of the selected source |
| call_ack | input | 1 | Core accepts the call |
| wake | output | 1 | Wake-up request |

## Verification
The request, the vector, the wake-up output and the read data are combinational from the stored bits. The bench therefore samples them one time unit after changing the register select, in the same low clock phase. Pulse flags and writes land at the next rising edge, so they are read at the following falling edge. Edge-detected flags need one more register stage and are checked two falling edges after the input drops. The bench also checks that they are still 0 after the first falling edge. Acknowledge effects are read one falling edge after `call_ack` is driven.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int NUM_SRC  = 6;
   localparam int NUM_EDGE = 3;
   localparam int SRC_IDX_W = $clog2(NUM_SRC);

   typedef enum logic [2:0] {
      SRC_CMP0 = 3'd0,
      SRC_CMP1 = 3'd1,
      SRC_EXT  = 3'd2,
      SRC_TMR0 = 3'd3,
      SRC_TMR1 = 3'd4,
      SRC_ADC  = 3'd5
   } irq_src_e;
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
   parameter int N           = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] fall
);
   logic [N-1:0] src;
   logic [N-1:0] cur_q;
   logic [N-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign src = din;
      end else begin : g_sync
         logic [N-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            end else begin
               sync_q[0] <= din;
               for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            end
         end
         assign src = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= src;
         prev_q <= cur_q;
      end
   end

   assign fall = prev_q & ~cur_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 6,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     grant
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |req;
   assign grant = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_vec_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [6:0]         wr_data,
   input  logic [NUM_SRC-1:0] hw_set,
   input  logic               ack_fire,
   input  logic [NUM_SRC-1:0] ack_grant,
   output logic               gie_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] flag_q
);
   logic               gie_d;
   logic [NUM_SRC-1:0] en_d;
   logic [NUM_SRC-1:0] flag_d;

   always_comb begin
      gie_d  = gie_q;
      en_d   = en_q;
      flag_d = flag_q;
      if (wr_en) begin
         if (wr_addr == 1'b0) begin
            gie_d       = wr_data[0];
            en_d[2:0]   = wr_data[3:1];
            flag_d[2:0] = wr_data[6:4];
         end else begin
            en_d[5:3]   = wr_data[2:0];
            flag_d[5:3] = wr_data[6:4];
         end
      end
      if (ack_fire) begin
         gie_d  = 1'b0;
         flag_d = flag_d & ~ack_grant;
      end
      flag_d = flag_d | hw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         gie_q  <= gie_d;
         en_q   <= en_d;
         flag_q <= flag_d;
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STEP    = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic             reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             cmp0_in,
   input  logic             cmp1_in,
   input  logic             ext_in,
   input  logic             tmr0_ovf,
   input  logic             tmr1_ovf,
   input  logic             adc_done,
   input  logic             stack_full,
   output logic             call_req,
   output logic [VEC_W-1:0] call_vec,
   input  logic             call_ack,
   output logic             wake
);
   localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

   generate
      if (VEC_LAST >= (1 << VEC_W)) begin : g_bad_vec_w
         $error("irq_vector_ctrl: VEC_W too narrow for the last vector");
      end
      if (VEC_STEP < 1) begin : g_bad_step
         $error("irq_vector_ctrl: VEC_STEP must be positive");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("irq_vector_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NUM_EDGE-1:0]  edge_fall;
   logic [NUM_SRC-1:0]   hw_set;
   logic                 gie_q;
   logic [NUM_SRC-1:0]   en_q;
   logic [NUM_SRC-1:0]   flag_q;
   logic [NUM_SRC-1:0]   eligible;
   logic                 any_elig;
   logic [SRC_IDX_W-1:0] win_idx;
   logic [NUM_SRC-1:0]   win_grant;
   logic                 ack_fire;
   logic                 unused_wbit;

   assign unused_wbit = reg_wdata[7];

   irq_fall_detect #(
      .N           (NUM_EDGE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ext_in, cmp1_in, cmp0_in}),
      .fall  (edge_fall)
   );

   assign hw_set = {adc_done, tmr1_ovf, tmr0_ovf, edge_fall};

   irq_flag_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_addr),
      .wr_data   (reg_wdata[6:0]),
      .hw_set    (hw_set),
      .ack_fire  (ack_fire),
      .ack_grant (win_grant),
      .gie_q     (gie_q),
      .en_q      (en_q),
      .flag_q    (flag_q)
   );

   assign eligible = en_q & flag_q;

   irq_prio_pick #(
      .N     (NUM_SRC),
      .IDX_W (SRC_IDX_W)
   ) u_pick (
      .req   (eligible),
      .any   (any_elig),
      .idx   (win_idx),
      .grant (win_grant)
   );

   assign call_req = gie_q & any_elig & ~stack_full;
   assign ack_fire = call_ack & call_req;
   assign wake     = any_elig;
   assign call_vec = any_elig ?
                     (VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP)) : '0;

   always_comb begin
      if (reg_addr == 1'b0)
         reg_rdata = {1'b0, flag_q[2:0], en_q[2:0], gie_q};
      else
         reg_rdata = {1'b0, flag_q[5:3], 1'b0, en_q[5:3]};
   end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_addr,
   input logic [7:0]       reg_rdata,
   input logic             tmr0_ovf,
   input logic             stack_full,
   input logic             call_req,
   input logic [VEC_W-1:0] call_vec,
   input logic             call_ack,
   input logic             wake,
   input logic             gie_q,
   input logic [5:0]       en_q,
   input logic [5:0]       flag_q
);
   localparam int VEC_LAST = VEC_BASE + 5 * VEC_STEP;

   assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] == 1'b0);

   assert_reg1_bit3_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr |-> reg_rdata[3] == 1'b0);

   assert_tmr_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr0_ovf |=> flag_q[3]);

   assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> (gie_q && !stack_full));

   assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> (int'(call_vec) >= VEC_BASE && int'(call_vec) <= VEC_LAST));

   assert_prio_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && en_q[0] && flag_q[0]) |-> int'(call_vec) == VEC_BASE);

   assert_ack_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (call_ack && call_req) |=> !gie_q);

   assert_req_has_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> wake);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .tmr0_ovf   (tmr0_ovf),
   .stack_full (stack_full),
   .call_req   (call_req),
   .call_vec   (call_vec),
   .call_ack   (call_ack),
   .wake       (wake),
   .gie_q      (gie_q),
   .en_q       (en_q),
   .flag_q     (flag_q)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       cmp0_in = 1'b0, cmp1_in = 1'b0, ext_in = 1'b0;
   logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, adc_done = 1'b0;
   logic       stack_full = 1'b0;
   logic       call_req;
   logic [7:0] call_vec;
   logic       call_ack = 1'b0;
   logic       wake;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk (clk), .rst_n (rst_n),
      .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .cmp0_in (cmp0_in), .cmp1_in (cmp1_in), .ext_in (ext_in),
      .tmr0_ovf (tmr0_ovf), .tmr1_ovf (tmr1_ovf), .adc_done (adc_done),
      .stack_full (stack_full),
      .call_req (call_req), .call_vec (call_vec), .call_ack (call_ack),
      .wake (wake)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(bit a, logic [7:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(bit a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      call_ack = 1'b1;
      @(negedge clk);
      call_ack = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(0, v); check("R1 reg0", v, 8'h00);
      rd(1, v); check("R1 reg1", v, 8'h00);
      check("R1 call_req", call_req, 0);
      check("R1 wake", wake, 0);
   endtask

   task automatic t_layout();
      logic [7:0] v;
      wr(0, 8'hFF);
      rd(0, v); check("R2 reg0 readback", v, 8'h7F);
      check("R7 cmp0 vector", call_vec, 8'h04);
      wr(0, 8'h00);
      wr(1, 8'hFF);
      rd(1, v); check("R3 reg1 readback", v, 8'h77);
      wr(1, 8'h00);
   endtask

   task automatic t_edges();
      logic [7:0] v;
      @(negedge clk); cmp0_in = 1'b1;
      @(negedge clk); @(negedge clk);
      cmp0_in = 1'b0;
      @(negedge clk);
      rd(0, v); check("R4 fall not yet", v, 8'h00);
      @(negedge clk);
      rd(0, v); check("R4 cmp0 fall sets flag", v, 8'h10);
      ext_in = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rd(0, v); check("R4 rise sets nothing", v, 8'h10);
      wr(0, 8'h00);
   endtask

   task automatic t_pulses();
      logic [7:0] v;
      @(negedge clk); tmr0_ovf = 1'b1;
      @(negedge clk); tmr0_ovf = 1'b0;
      rd(1, v); check("R5 tmr0 flag", v, 8'h10);
      check("R11 no wake when disabled", wake, 0);
      adc_done = 1'b1;
      @(negedge clk); adc_done = 1'b0;
      rd(1, v); check("R5 adc flag", v, 8'h50);
      wr(1, 8'h11);
      check("R11 wake with gie 0", wake, 1);
      check("R6 no req with gie 0", call_req, 0);
      wr(0, 8'h01);
      check("R6 req", call_req, 1);
      check("R7 tmr0 vector", call_vec, 8'h10);
      stack_full = 1'b1; #1;
      check("R6 stack full blocks", call_req, 0);
      check("R11 wake while stack full", wake, 1);
      stack_full = 1'b0; #1;
   endtask

   task automatic t_ack();
      logic [7:0] v;
      ack_pulse();
      check("R9 req drops after ack", call_req, 0);
      rd(0, v); check("R9 gie cleared", v, 8'h00);
      rd(1, v); check("R9 flag cleared", v, 8'h01);
      @(negedge clk); tmr1_ovf = 1'b1;
      @(negedge clk); tmr1_ovf = 1'b0;
      rd(1, v); check("R10 masked flag latched", v, 8'h21);
      ack_pulse();
      rd(1, v); check("R9 ack ignored without req", v, 8'h21);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      @(negedge clk);
      tmr1_ovf = 1'b1; reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h07;
      @(negedge clk);
      tmr1_ovf = 1'b0; reg_wr_en = 1'b0;
      rd(1, v); check("R12 hw set wins", v, 8'h27);
   endtask

   task automatic t_nesting();
      logic [7:0] v;
      wr(1, 8'h77);
      wr(0, 8'h7F);
      for (int i = 0; i < 6; i++) begin
         check("R8 req pending", call_req, 1);
         check("R8 lowest vector", call_vec, 4 + 4 * i);
         ack_pulse();
         check("R10 masked after ack", call_req, 0);
         rd(0, v);
         wr(0, v | 8'h01);
      end
      rd(0, v); check("R10 reg0 after all", v, 8'h0F);
      rd(1, v); check("R10 reg1 after all", v, 8'h07);
      check("R11 wake idle", wake, 0);
      check("R7 idle vector", call_vec, 0);
   endtask

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_edges();
      t_pulses();
      t_ack();
      t_collide();
      t_nesting();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule